// File: doc/BRIEF.md
# 32-bit Integer ALU with Shared Subtract Path

This block is the execute-stage arithmetic and logic unit of a small RISC datapath. It is purely combinational: two operands and a 3-bit operation code go in, and a result word and three condition flags (zero, signed overflow and carry-out) come out in the same cycle. It performs bitwise AND, bitwise OR, addition, subtraction and set-on-less-than.

One adder serves every arithmetic operation. The top bit of the operation code inverts operand B and also supplies the carry into bit 0, so subtraction is A plus the inverse of B plus one. Set-on-less-than runs the same subtraction and reports the sign of the raw difference in bit 0. The adder is built from a parameter: either a bit-serial ripple chain or a chain of fixed-size lookahead groups. The data width is also a parameter, and its default is 32.

Top module: `int_alu32`

## Requirements
- R1: Operation code 000 gives result = A AND B, bit by bit.
- R2: Operation code 001 gives result = A OR B, bit by bit.
- R3: Operation code 010 gives result = (A + B) modulo 2^W. Carry-out is the carry leaving the most significant bit of that sum.
- R4: Operation code 110 gives result = A + ~B + 1 (modulo 2^W), which equals A - B. Carry-out is the carry leaving the most significant bit of that sum, so it is 1 exactly when A >= B as unsigned numbers.
- R5: Operation code 111 gives result bit 0 = bit W-1 of (A + ~B + 1), with result bits W-1 down to 1 all 0. Carry-out and overflow follow that subtraction.
- R6: For operation codes 010, 110 and 111, overflow is the XOR of the carry into the most significant adder bit and the carry out of it.
- R7: Zero is 1 exactly when every bit of the result is 0, for every operation code.
- R8: For operation codes 000 and 001, overflow and carry-out are both 0.
- R9: Operation codes 011, 100 and 101 give result 0, overflow 0, carry-out 0, and therefore zero = 1.
- R10: No overflow correction is applied to set-on-less-than. When A and B have opposite signs and the difference overflows, bit 0 is still the raw sign of the difference. For example, A = 0x7FFFFFFF and B = 0x80000000 give result 1.
- R11: The outputs depend only on the present inputs. No state is held, and a new input value is reflected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W (32) | First operand |
| b_i | input | W (32) | Second operand; inverted internally for subtract and set-on-less-than |
| op_i | input | 3 | Operation code |
| result_o | output | W (32) | Result word |
| zero_o | output | 1 | High when the result is all zeros |
| ovf_o | output | 1 | Signed overflow of the arithmetic operation |
| cout_o | output | 1 | Carry out of the most significant adder bit |

## Verification
Every result and flag is due in the same cycle as the stimulus, because there is no register between the inputs and the outputs. The bench drives new operands just after a rising clock edge. It samples all four outputs 5 ns later, well inside the 20 ns period, so the combinational path has settled and no sample depends on the order of processes at an edge. Each sample is compared with a value computed from the requirements using a wider addition. The directed corner cases are overflow in both directions, the raw set-on-less-than sign under overflow, the all-ones and all-zeros operands, and the unused codes. Seeded random operands are then run across all five operations.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_AND = 3'b000,
      OP_OR  = 3'b001,
      OP_ADD = 3'b010,
      OP_SUB = 3'b110,
      OP_SLT = 3'b111
   } alu_op_e;

   localparam int ADDER_RIPPLE    = 0;
   localparam int ADDER_LOOKAHEAD = 1;

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sel_or_i,
   output logic [W-1:0] y_o
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign y_o[i] = sel_or_i ? (a_i[i] | b_i[i]) : (a_i[i] & b_i[i]);
   end

   // R1 / R2: the bit cell agrees with the word-level operation
   always_comb begin
      if (sel_or_i) a_r2_or_word: assert (y_o == (a_i | b_i));
      else          a_r1_and_word: assert (y_o == (a_i & b_i));
   end

endmodule

// File: rtl/alu_adder.sv
module alu_adder
   import int_alu_pkg::*;
#(
   parameter int W          = 32,
   parameter int KIND       = ADDER_LOOKAHEAD,
   parameter int GROUP      = 4
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         c_msb_in_o,
   output logic         c_out_o
);

   localparam int NGRP = (GROUP > 0) ? (W / GROUP) : 1;

   logic [W:0] c;

   if (KIND != ADDER_RIPPLE && KIND != ADDER_LOOKAHEAD) begin : g_bad_kind
      $error("alu_adder: unknown adder kind");
   end
   if (KIND == ADDER_LOOKAHEAD && (GROUP < 2 || (W % GROUP) != 0)) begin : g_bad_group
      $error("alu_adder: width must be a multiple of a group size of at least 2");
   end

   assign c[0] = cin_i;

   if (KIND == ADDER_RIPPLE) begin : g_ripple
      for (genvar i = 0; i < W; i++) begin : g_cell
         assign c[i+1] = (a_i[i] & b_i[i]) | (a_i[i] & c[i]) | (b_i[i] & c[i]);
      end
   end else begin : g_lookahead
      logic [NGRP:0] gc;
      assign gc[0] = cin_i;
      for (genvar k = 0; k < NGRP; k++) begin : g_grp
         logic [GROUP-1:0] gen, prp, lc;
         logic             grp_g, grp_p;
         assign gen = a_i[k*GROUP +: GROUP] & b_i[k*GROUP +: GROUP];
         assign prp = a_i[k*GROUP +: GROUP] | b_i[k*GROUP +: GROUP];
         always_comb begin
            grp_g = gen[0];
            grp_p = prp[0];
            for (int j = 1; j < GROUP; j++) begin
               grp_g = gen[j] | (prp[j] & grp_g);
               grp_p = grp_p & prp[j];
            end
         end
         always_comb begin
            lc[0] = gc[k];
            for (int j = 0; j < GROUP-1; j++) begin
               lc[j+1] = gen[j] | (prp[j] & lc[j]);
            end
         end
         assign gc[k+1] = grp_g | (grp_p & gc[k]);
         for (genvar j = 1; j < GROUP; j++) begin : g_inner
            assign c[k*GROUP+j] = lc[j];
         end
         assign c[(k+1)*GROUP] = gc[k+1];
      end
   end

   for (genvar i = 0; i < W; i++) begin : g_sum
      assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
   end

   assign c_msb_in_o = c[W-1];
   assign c_out_o    = c[W];

   // R3: carry chain and sum match a wide behavioural addition
   always_comb begin
      a_r3_adder_sum: assert ({c_out_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}));
   end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
   parameter int W = 32
) (
   input  logic [W-1:0] result_i,
   input  logic         c_msb_in_i,
   input  logic         c_out_i,
   input  logic         arith_i,
   output logic         zero_o,
   output logic         ovf_o,
   output logic         cout_o
);

   assign zero_o = ~|result_i;
   assign ovf_o  = arith_i & (c_msb_in_i ^ c_out_i);
   assign cout_o = arith_i & c_out_i;

   // R7: a nonzero population count rules out the zero flag
   always_comb begin
      a_r7_zero_count: assert (zero_o == ($countones(result_i) == 0));
   end

endmodule

// File: rtl/int_alu32.sv
module int_alu32
   import int_alu_pkg::*;
#(
   parameter int W          = 32,
   parameter int ADDER_KIND = ADDER_LOOKAHEAD,
   parameter int GROUP      = 4
) (
   input  logic [W-1:0]    a_i,
   input  logic [W-1:0]    b_i,
   input  logic [OP_W-1:0] op_i,
   output logic [W-1:0]    result_o,
   output logic            zero_o,
   output logic            ovf_o,
   output logic            cout_o
);

   localparam int MSB = W - 1;

   if (W < 2) begin : g_bad_width
      $error("int_alu32: width must be at least 2");
   end

   logic         binv;
   logic         arith;
   logic [W-1:0] b_eff;
   logic [W-1:0] logic_y;
   logic [W-1:0] sum;
   logic         c_msb_in;
   logic         c_out;

   // top opcode bit both inverts B and feeds carry into bit 0
   assign binv  = op_i[2];
   assign b_eff = b_i ^ {W{binv}};

   always_comb begin
      case (op_i)
         OP_ADD, OP_SUB, OP_SLT: arith = 1'b1;
         default:                arith = 1'b0;
      endcase
   end

   alu_logic_unit #(.W(W)) u_logic (
      .a_i      (a_i),
      .b_i      (b_i),
      .sel_or_i (op_i[0]),
      .y_o      (logic_y)
   );

   alu_adder #(.W(W), .KIND(ADDER_KIND), .GROUP(GROUP)) u_adder (
      .a_i        (a_i),
      .b_i        (b_eff),
      .cin_i      (binv),
      .sum_o      (sum),
      .c_msb_in_o (c_msb_in),
      .c_out_o    (c_out)
   );

   always_comb begin
      case (op_i)
         OP_AND, OP_OR:  result_o = logic_y;
         OP_ADD, OP_SUB: result_o = sum;
         OP_SLT:         result_o = {{(W-1){1'b0}}, sum[MSB]};
         default:        result_o = '0;
      endcase
   end

   alu_flag_unit #(.W(W)) u_flags (
      .result_i   (result_o),
      .c_msb_in_i (c_msb_in),
      .c_out_i    (c_out),
      .arith_i    (arith),
      .zero_o     (zero_o),
      .ovf_o      (ovf_o),
      .cout_o     (cout_o)
   );

   always_comb begin
      if (op_i == OP_SUB) begin
         a_r4_sub_difference: assert (result_o == (a_i - b_i));
      end
      if (op_i == OP_SLT) begin
         a_r5_slt_upper_clear: assert (result_o[MSB:1] == '0);
         a_r10_slt_raw_sign: assert (result_o[0] == ((a_i - b_i) >> MSB));
      end
      if (arith) begin
         a_r6_overflow_sign_rule: assert (ovf_o == ((a_i[MSB] == b_eff[MSB]) && (sum[MSB] != a_i[MSB])));
      end
      if (op_i == OP_AND || op_i == OP_OR) begin
         a_r8_logic_no_flags: assert (!ovf_o && !cout_o);
      end
      if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101) begin
         a_r9_unused_quiet: assert (result_o == '0 && zero_o && !ovf_o && !cout_o);
      end
   end

endmodule

// File: tb/int_alu32_bench.sv
module int_alu32_bench;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic [W-1:0] a, b;
   logic [2:0]   op;
   logic [W-1:0] result;
   logic         zero, ovf, cout;

   int tests_run = 0;
   int tests_failed = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   int_alu32 #(.W(W)) u_int_alu32 (
      .a_i      (a),
      .b_i      (b),
      .op_i     (op),
      .result_o (result),
      .zero_o   (zero),
      .ovf_o    (ovf),
      .cout_o   (cout)
   );

   // drive after an edge, sample 5 ns later (same cycle, combinational)
   task automatic check(input string tag, input logic [2:0] o,
                        input logic [W-1:0] x, input logic [W-1:0] y);
      logic [W-1:0] bb, s, er;
      logic [W:0]   wide;
      logic         cin, v, c, ez, ev, ec;
      @(posedge clk);
      op = o; a = x; b = y;
      #5;
      cin  = o[2];
      bb   = cin ? ~y : y;
      wide = {1'b0, x} + {1'b0, bb} + {{W{1'b0}}, cin};
      s    = wide[W-1:0];
      c    = wide[W];
      v    = (x[W-1] == bb[W-1]) && (s[W-1] != x[W-1]);
      case (o)
         3'b000: begin er = x & y; ev = 0; ec = 0; end
         3'b001: begin er = x | y; ev = 0; ec = 0; end
         3'b010, 3'b110: begin er = s; ev = v; ec = c; end
         3'b111: begin er = {{(W-1){1'b0}}, s[W-1]}; ev = v; ec = c; end
         default: begin er = '0; ev = 0; ec = 0; end
      endcase
      ez = (er == '0);
      tests_run++;
      if (result !== er || zero !== ez || ovf !== ev || cout !== ec) begin
         tests_failed++;
         $display("FAIL %s op=%b a=%h b=%h actual res=%h z=%b v=%b c=%b expected res=%h z=%b v=%b c=%b",
                  tag, o, x, y, result, zero, ovf, cout, er, ez, ev, ec);
      end
   endtask

   task automatic t_idle();   // R11 R1 R7: all-zero inputs at start
      check("R11 idle", 3'b000, '0, '0);
      check("R7 zero after and", 3'b000, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
   endtask

   task automatic t_logic();  // R1 R2 R8
      check("R1 and", 3'b000, 32'hDEAD_BEEF, 32'h0FF0_F00F);
      check("R1 and ones", 3'b000, 32'hFFFF_FFFF, 32'h1234_5678);
      check("R2 or", 3'b001, 32'hA5A5_0000, 32'h0000_5A5A);
      check("R2 or zero", 3'b001, '0, '0);
      check("R8 and no flags", 3'b000, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      check("R8 or no flags", 3'b001, 32'h8000_0000, 32'h8000_0000);
   endtask

   task automatic t_add();    // R3 R6
      check("R3 add small", 3'b010, 32'd3, 32'd2);
      check("R3 add carry out", 3'b010, 32'hFFFF_FFFF, 32'd1);
      check("R6 add pos overflow", 3'b010, 32'h7FFF_FFFF, 32'd1);
      check("R6 add neg overflow", 3'b010, 32'h8000_0000, 32'h8000_0000);
      check("R3 add mixed", 3'b010, 32'hFFFF_FFFA, 32'd7);
   endtask

   task automatic t_sub();    // R4 R6 R7
      check("R4 sub basic", 3'b110, 32'd7, 32'd6);
      check("R4 sub borrow", 3'b110, 32'd3, 32'd5);
      check("R7 sub equal", 3'b110, 32'h1234_5678, 32'h1234_5678);
      check("R6 sub overflow", 3'b110, 32'h8000_0000, 32'd1);
      check("R4 sub zero minus zero", 3'b110, '0, '0);
   endtask

   task automatic t_slt();    // R5 R10
      check("R5 slt less", 3'b111, 32'hFFFF_FFFE, 32'd1);
      check("R5 slt greater", 3'b111, 32'd9, 32'd4);
      check("R5 slt equal", 3'b111, 32'd4, 32'd4);
      check("R10 slt raw pos-neg", 3'b111, 32'h7FFF_FFFF, 32'h8000_0000);
      check("R10 slt raw neg-pos", 3'b111, 32'h8000_0000, 32'd1);
   endtask

   task automatic t_unused(); // R9
      check("R9 code 011", 3'b011, 32'hFFFF_FFFF, 32'h1);
      check("R9 code 100", 3'b100, 32'h1234_5678, 32'h8765_4321);
      check("R9 code 101", 3'b101, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
   endtask

   task automatic t_random(); // R1 R2 R3 R4 R5 R6 R7
      logic [2:0] ops [5];
      ops[0] = 3'b000; ops[1] = 3'b001; ops[2] = 3'b010;
      ops[3] = 3'b110; ops[4] = 3'b111;
      for (int i = 0; i < 400; i++) begin
         logic [W-1:0] x, y;
         x = $urandom;
         y = (i % 7 == 0) ? x : $urandom;
         check("R6 random", ops[i % 5], x, y);
      end
   endtask

   initial begin
      a = '0; b = '0; op = 3'b000;
      t_idle();
      t_logic();
      t_add();
      t_sub();
      t_slt();
      t_unused();
      t_random();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         tests_run++;
         tests_failed++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
         $finish;
      end
   end

endmodule